// File: doc/BRIEF.md
# Ethernet receive descriptor DMA engine

This block moves received Ethernet frame bytes from a MAC-side byte stream into system memory. Software builds a ring of descriptors. Each descriptor names a data buffer and its size, and a second ring of the same length holds status elements. Software sets the base address of each ring, the ring length and its consume index through a small register port, and then enables the engine. For each descriptor the engine fetches the buffer pointer and the control word, stores the frame bytes into the buffer, and writes a two-word status element. It then advances its produce index and can raise a done interrupt.

A frame larger than one buffer is split into fragments that occupy consecutive descriptors. Every fragment's status carries the same pair of 9-bit address hashes, one for the destination address and one for the source address. One descriptor is always left unused, so a full ring can be told apart from an empty one. A frame that finds the ring full is discarded and flagged through a sticky overflow output.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset the produce index is 0, the interrupt and the overflow output are low, the stream ready is low and no memory access is made. While the enable bit is 0, no byte is accepted and memory is not touched.
- R2: For slot p the engine reads the word at desc_base+8*p as the byte-aligned buffer base address. It reads the word at desc_base+8*p+4 as the control word: bits 10:0 hold the buffer size minus one, bit 31 requests the interrupt and bits 30:11 are ignored.
- R3: Each accepted byte is written to the next byte address of the buffer. The write goes to the word address with only the byte lane selected by address bits 1:0, so neighbouring bytes are left unchanged.
- R4: The status info word at stat_base+8*p holds the number of bytes written minus one in bits 10:0, the last-fragment flag in bit 30 and the fragment overflow flag in bit 31. All other bits are 0.
- R5: When a buffer fills before the end-of-frame byte, its descriptor is closed as a non-last fragment and the frame continues in the next descriptor.
- R6: The hash word at stat_base+8*p+4 holds the destination hash in bits 24:16 and the source hash in bits 8:0. Each hash is the low 9 bits of the Ethernet CRC-32 over a 6-byte address. The CRC is reflected, with polynomial 0xEDB88320, initial value all ones and a final complement. The destination address is frame bytes 0-5 and the source address is frame bytes 6-11. Every fragment closed after byte 11 carries the same value. A fragment closed earlier carries 0.
- R7: The produce index advances by one only after both status words of a fragment are written. It wraps to 0 after ring_len-1.
- R8: The done interrupt is a one-cycle pulse in the cycle the produce index advances, and only for a descriptor whose control bit 31 is set.
- R9: The ring is full when produce+1 (wrapped) equals the consume index. A frame that starts while the ring is full is discarded whole: the overflow output rises, no memory is written and the produce index holds.
- R10: If a non-last fragment closes and the ring is then full, the fragment's status has its overflow flag set, the rest of the frame is discarded and the overflow output rises.
- R11: The overflow output stays high until software writes 1 to bit 1 of the control register.
- R12: The register addresses are: 0 for the descriptor base, 1 for the status base, 2 for the ring length in descriptors, 3 for the consume index and 4 for control (bit 0 enable, bit 1 write-one to clear overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| produce_idx | output | IDX_W | Produce index |
| rx_done_irq | output | 1 | Done interrupt pulse |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The descriptor fetch takes three cycles between seeing the first byte of a frame and asserting ready. A closing byte is followed by the info write, then the hash write, and the produce step and interrupt come in the third cycle after the edge that accepted that byte. The bench waits eight cycles after the last byte of each frame before it reads the memory image, the produce index and the overflow flag. It samples every output and counts interrupt pulses on the falling edge, so no result is taken in the cycle it changes.

// File: rtl/rx_desc_dma_pkg.sv
package rx_desc_dma_pkg;

    localparam int SIZE_W   = 11;
    localparam int LAST_BIT = 30;
    localparam int OVF_BIT  = 31;
    localparam int IRQ_BIT  = 31;
    localparam int ADDR_BYTES = 12;

    localparam logic [2:0] REG_DESC_BASE = 3'd0;
    localparam logic [2:0] REG_STAT_BASE = 3'd1;
    localparam logic [2:0] REG_RING_LEN  = 3'd2;
    localparam logic [2:0] REG_CONSUME   = 3'd3;
    localparam logic [2:0] REG_CONTROL   = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_PTR,
        ST_RD_CTRL,
        ST_LATCH,
        ST_DATA,
        ST_WR_INFO,
        ST_WR_HASH,
        ST_ADVANCE,
        ST_DROP
    } dma_state_e;

    typedef struct packed {
        logic              irq_req;
        logic [SIZE_W-1:0] size_m1;
    } desc_ctrl_t;

    typedef struct packed {
        logic              ovf;
        logic              last;
        logic [SIZE_W-1:0] len_m1;
    } frag_info_t;

    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [31:0] info_word(input frag_info_t fi);
        logic [31:0] w;
        w = '0;
        w[SIZE_W-1:0] = fi.len_m1;
        w[LAST_BIT]   = fi.last;
        w[OVF_BIT]    = fi.ovf;
        return w;
    endfunction

    function automatic logic [31:0] pack_hash(input logic [8:0] dst9,
                                              input logic [8:0] src9);
        return {7'd0, dst9, 7'd0, src9};
    endfunction

endpackage

// File: rtl/rx_desc_dma_regs.sv
module rx_desc_dma_regs
    import rx_desc_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [ADDR_W-1:0] desc_base,
    output logic [ADDR_W-1:0] stat_base,
    output logic [IDX_W-1:0]  ring_len,
    output logic [IDX_W-1:0]  consume_idx,
    output logic              engine_en,
    output logic              ovf_clr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_base   <= '0;
            stat_base   <= '0;
            ring_len    <= '0;
            consume_idx <= '0;
            engine_en   <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_DESC_BASE: desc_base   <= reg_wdata[ADDR_W-1:0];
                REG_STAT_BASE: stat_base   <= reg_wdata[ADDR_W-1:0];
                REG_RING_LEN:  ring_len    <= reg_wdata[IDX_W-1:0];
                REG_CONSUME:   consume_idx <= reg_wdata[IDX_W-1:0];
                REG_CONTROL:   engine_en   <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    assign ovf_clr = reg_we && (reg_addr == REG_CONTROL) && reg_wdata[1];

endmodule

// File: rtl/rx_desc_dma_ring.sv
module rx_desc_dma_ring #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [IDX_W-1:0] ring_len,
    input  logic [IDX_W-1:0] consume_idx,
    output logic [IDX_W-1:0] produce_idx,
    output logic             full_now,
    output logic             full_after
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [IDX_W-1:0] produce_q;
    logic [IDX_W-1:0] next1;
    logic [IDX_W-1:0] next2;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] idx,
                                                  input logic [IDX_W-1:0] len);
        return (idx >= len - ONE) ? '0 : idx + ONE;
    endfunction

    assign next1 = wrap_inc(produce_q, ring_len);
    assign next2 = wrap_inc(next1, ring_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            produce_q <= '0;
        end else if (advance) begin
            produce_q <= next1;
        end
    end

    assign produce_idx = produce_q;
    assign full_now    = (next1 == consume_idx);
    assign full_after  = (next2 == consume_idx);

endmodule

// File: rtl/rx_desc_dma_hash.sv
module rx_desc_dma_hash
    import rx_desc_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    output logic [31:0] hash_word
);

    logic [3:0]  pos_q;
    logic [31:0] dst_crc_q;
    logic [31:0] src_crc_q;
    logic        done;

    assign done = (pos_q == 4'(ADDR_BYTES));

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            pos_q     <= '0;
            dst_crc_q <= '1;
            src_crc_q <= '1;
        end else if (byte_vld && !done) begin
            if (pos_q < 4'(ADDR_BYTES / 2)) begin
                dst_crc_q <= crc32_byte(dst_crc_q, byte_data);
            end else begin
                src_crc_q <= crc32_byte(src_crc_q, byte_data);
            end
            pos_q <= pos_q + 4'd1;
        end
    end

    assign hash_word = done ? pack_hash(~dst_crc_q[8:0], ~src_crc_q[8:0]) : '0;

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rx_desc_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [IDX_W-1:0]  produce_idx,
    output logic              rx_done_irq,
    output logic              overflow
);

    localparam logic [ADDR_W-1:0] WORD_OFS = ADDR_W'(4);

    logic [ADDR_W-1:0] desc_base;
    logic [ADDR_W-1:0] stat_base;
    logic [IDX_W-1:0]  ring_len;
    logic [IDX_W-1:0]  consume_idx;
    logic              engine_en;
    logic              ovf_clr;
    logic              full_now;
    logic              full_after;
    logic              advance;
    logic [31:0]       hash_w;

    dma_state_e        state_q, state_d;
    logic [ADDR_W-1:0] buf_ptr_q;
    desc_ctrl_t        ctrl_q;
    frag_info_t        info_q;
    logic [SIZE_W-1:0] byte_cnt_q;
    logic              overflow_q;

    logic              byte_acc;
    logic              close_frag;
    logic              ovf_set;
    logic              frame_start;
    logic [ADDR_W-1:0] desc_slot;
    logic [ADDR_W-1:0] stat_slot;

    rx_desc_dma_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .desc_base   (desc_base),
        .stat_base   (stat_base),
        .ring_len    (ring_len),
        .consume_idx (consume_idx),
        .engine_en   (engine_en),
        .ovf_clr     (ovf_clr)
    );

    rx_desc_dma_ring #(.IDX_W(IDX_W)) u_ring (
        .clk         (clk),
        .rst         (rst),
        .advance     (advance),
        .ring_len    (ring_len),
        .consume_idx (consume_idx),
        .produce_idx (produce_idx),
        .full_now    (full_now),
        .full_after  (full_after)
    );

    rx_desc_dma_hash u_hash (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .byte_vld    (byte_acc),
        .byte_data   (in_data),
        .hash_word   (hash_w)
    );

    assign desc_slot  = desc_base + ADDR_W'({produce_idx, 3'b000});
    assign stat_slot  = stat_base + ADDR_W'({produce_idx, 3'b000});
    assign byte_acc   = (state_q == ST_DATA) && in_valid;
    assign close_frag = byte_acc && (in_last || (byte_cnt_q == ctrl_q.size_m1));

    // Next state and per-cycle events
    always_comb begin
        state_d     = state_q;
        ovf_set     = 1'b0;
        frame_start = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (engine_en && in_valid) begin
                    if (full_now) begin
                        ovf_set = 1'b1;
                        state_d = ST_DROP;
                    end else begin
                        frame_start = 1'b1;
                        state_d     = ST_RD_PTR;
                    end
                end
            end
            ST_RD_PTR:  state_d = ST_RD_CTRL;
            ST_RD_CTRL: state_d = ST_LATCH;
            ST_LATCH:   state_d = ST_DATA;
            ST_DATA: begin
                if (close_frag) state_d = ST_WR_INFO;
            end
            ST_WR_INFO: state_d = ST_WR_HASH;
            ST_WR_HASH: state_d = ST_ADVANCE;
            ST_ADVANCE: begin
                if (info_q.last) begin
                    state_d = ST_IDLE;
                end else if (info_q.ovf) begin
                    ovf_set = 1'b1;
                    state_d = ST_DROP;
                end else begin
                    state_d = ST_RD_PTR;
                end
            end
            ST_DROP: begin
                if (in_valid && in_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Memory port and stream handshake
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        in_ready  = 1'b0;
        advance   = 1'b0;
        case (state_q)
            ST_RD_PTR: begin
                mem_en   = 1'b1;
                mem_addr = desc_slot;
            end
            ST_RD_CTRL: begin
                mem_en   = 1'b1;
                mem_addr = desc_slot + WORD_OFS;
            end
            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {buf_ptr_q[ADDR_W-1:2], 2'b00};
                    mem_be    = 4'b0001 << buf_ptr_q[1:0];
                    mem_wdata = {4{in_data}};
                end
            end
            ST_WR_INFO: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_slot;
                mem_be    = 4'hF;
                mem_wdata = info_word(info_q);
            end
            ST_WR_HASH: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_slot + WORD_OFS;
                mem_be    = 4'hF;
                mem_wdata = hash_w;
            end
            ST_ADVANCE: advance  = 1'b1;
            ST_DROP:    in_ready = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            buf_ptr_q  <= '0;
            ctrl_q     <= '0;
            info_q     <= '0;
            byte_cnt_q <= '0;
            overflow_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ovf_set) begin
                overflow_q <= 1'b1;
            end else if (ovf_clr) begin
                overflow_q <= 1'b0;
            end
            if (state_q == ST_RD_CTRL) begin
                buf_ptr_q <= mem_rdata[ADDR_W-1:0];
            end
            if (state_q == ST_LATCH) begin
                ctrl_q.irq_req <= mem_rdata[IRQ_BIT];
                ctrl_q.size_m1 <= mem_rdata[SIZE_W-1:0];
                byte_cnt_q     <= '0;
            end
            if (byte_acc) begin
                buf_ptr_q  <= buf_ptr_q + ADDR_W'(1);
                byte_cnt_q <= byte_cnt_q + SIZE_W'(1);
            end
            if (close_frag) begin
                info_q.len_m1 <= byte_cnt_q;
                info_q.last   <= in_last;
                info_q.ovf    <= !in_last && full_after;
            end
        end
    end

    assign rx_done_irq = (state_q == ST_ADVANCE) && ctrl_q.irq_req;
    assign overflow    = overflow_q;

endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_done_irq,
    input logic [IDX_W-1:0] produce_idx,
    input logic             overflow,
    input logic             ovf_clr,
    input logic             in_ready,
    input logic             mem_en,
    input logic             mem_we
);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done_irq |=> !rx_done_irq);

    // R8
    irq_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done_irq |-> $past(mem_en && mem_we));

    // R7
    produce_step_chk: assert property (@(posedge clk) disable iff (rst)
        (produce_idx != $past(produce_idx)) |->
            (produce_idx == '0 || produce_idx == IDX_W'($past(produce_idx) + 1'b1)));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    // R2
    no_accept_on_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |-> !in_ready);

endmodule

bind rx_desc_dma rx_desc_dma_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_done_irq (rx_done_irq),
    .produce_idx (produce_idx),
    .overflow    (overflow),
    .ovf_clr     (ovf_clr),
    .in_ready    (in_ready),
    .mem_en      (mem_en),
    .mem_we      (mem_we)
);

// File: tb/rx_desc_dma_tb_top.sv
`timescale 1ns/1ps
module rx_desc_dma_tb_top;

    localparam int ADDR_W = 32;
    localparam int IDX_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [IDX_W-1:0]  produce_idx;
    logic              rx_done_irq;
    logic              overflow;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    logic [31:0] mem [int unsigned];
    logic [7:0]  fr [$];

    always #2.5 clk = ~clk;

    rx_desc_dma #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .produce_idx(produce_idx), .rx_done_irq(rx_done_irq), .overflow(overflow)
    );

    function automatic logic [31:0] rdw(input logic [31:0] a);
        return mem.exists(a >> 2) ? mem[a >> 2] : 32'd0;
    endfunction

    function automatic logic [7:0] rdb(input logic [31:0] a);
        logic [31:0] w;
        w = rdw(a);
        return w[8*a[1:0] +: 8];
    endfunction

    // memory model: one-cycle read latency, byte-lane writes
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                logic [31:0] w;
                w = rdw(mem_addr);
                for (int k = 0; k < 4; k++) if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
                mem[mem_addr >> 2] = w;
            end else begin
                mem_rdata <= rdw(mem_addr);
            end
        end
    end

    always @(negedge clk) if (!rst && rx_done_irq) irq_cnt++;

    function automatic logic [8:0] addr_hash(input int start);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            c = c ^ {24'd0, fr[start+i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        c = ~c;
        return c[8:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build(input logic [7:0] seed, input int n);
        fr.delete();
        for (int i = 0; i < n; i++) fr.push_back(seed + 8'(i * 7));
    endtask

    task automatic send_frame();
        for (int i = 0; i < fr.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fr[i];
            in_last  = (i == fr.size() - 1);
            forever begin
                if (in_ready) begin
                    @(posedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_desc(input int slot, input logic [31:0] bufa, input logic [31:0] ctrl);
        mem[(32'h1000 + 8*slot) >> 2]     = bufa;
        mem[(32'h1000 + 8*slot + 4) >> 2] = ctrl;
    endtask

    // compares one fragment's bytes, info word and hash word
    task automatic check_frag(input string req, input int slot, input logic [31:0] bufa,
                              input int off, input int len, input bit last, input bit ovf);
        logic [31:0] exp_info, exp_hash;
        for (int i = 0; i < len; i++) chk({req, " R3 data byte"}, 32'(rdb(bufa + i)), 32'(fr[off+i]));
        exp_info = 32'(len - 1) | (32'(last) << 30) | (32'(ovf) << 31);
        chk({req, " R4 info"}, rdw(32'h2000 + 8*slot), exp_info);
        exp_hash = (off + len >= 12) ? {7'd0, addr_hash(0), 7'd0, addr_hash(6)} : 32'd0;
        chk({req, " R6 hash"}, rdw(32'h2000 + 8*slot + 4), exp_hash);
    endtask

    initial begin
        int busy;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 produce", 32'(produce_idx), 0);
        chk("R1 irq", 32'(rx_done_irq), 0);
        chk("R1 overflow", 32'(overflow), 0);
        chk("R1 ready", 32'(in_ready), 0);
        rst = 1'b0;
        // R1: disabled engine ignores the stream
        busy = 0;
        in_valid = 1'b1; in_data = 8'hAA;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (in_ready || mem_en) busy++;
        end
        in_valid = 1'b0;
        chk("R1 disabled no activity", 32'(busy), 0);

        set_desc(0, 32'h4001, 32'h8000_003F);
        set_desc(1, 32'h4101, 32'h0000_0007);
        set_desc(2, 32'h4201, 32'h8010_003F);  // bit 20 set, ignored (R2)
        set_desc(3, 32'h4301, 32'h8000_0007);
        // R12 register map
        wreg(3'd0, 32'h1000);
        wreg(3'd1, 32'h2000);
        wreg(3'd2, 32'd4);
        wreg(3'd3, 32'd0);
        wreg(3'd4, 32'd1);

        // Frame A: single fragment in unaligned buffer
        build(8'h10, 20);
        send_frame();
        check_frag("A R2", 0, 32'h4001, 0, 20, 1, 0);
        chk("A R3 lane untouched", 32'(rdb(32'h4000)), 0);
        chk("A R7 produce", 32'(produce_idx), 1);
        chk("A R8 irq count", 32'(irq_cnt), 1);

        // Frame B: spans an 8-byte buffer then continues (R5)
        build(8'h50, 20);
        send_frame();
        check_frag("B R5 first", 1, 32'h4101, 0, 8, 0, 0);
        check_frag("B R5 second", 2, 32'h4201, 8, 12, 1, 0);
        chk("B R7 produce", 32'(produce_idx), 3);
        chk("B R8 irq only on flagged slot", 32'(irq_cnt), 2);

        // Frame C: ring full at start (R9)
        build(8'h70, 10);
        send_frame();
        chk("C R9 overflow", 32'(overflow), 1);
        chk("C R9 produce held", 32'(produce_idx), 3);
        chk("C R9 no data write", 32'(rdb(32'h4301)), 0);
        chk("C R9 no status write", rdw(32'h2000 + 24), 0);
        chk("C R8 no irq", 32'(irq_cnt), 2);
        repeat (20) @(negedge clk);
        chk("C R11 sticky", 32'(overflow), 1);
        wreg(3'd4, 32'd3);
        chk("C R11 cleared", 32'(overflow), 0);

        // Frame D: ring becomes full mid-frame (R10), produce wraps (R7)
        wreg(3'd3, 32'd1);
        build(8'h90, 16);
        send_frame();
        check_frag("D R10", 3, 32'h4301, 0, 8, 0, 1);
        chk("D R10 tail dropped", 32'(rdb(32'h4309)), 0);
        chk("D R10 overflow", 32'(overflow), 1);
        chk("D R7 wrap", 32'(produce_idx), 0);
        chk("D R8 irq", 32'(irq_cnt), 3);

        // Frame E: runt shorter than the addresses
        wreg(3'd4, 32'd3);
        wreg(3'd3, 32'd0);
        build(8'hC0, 5);
        send_frame();
        check_frag("E R6 runt", 0, 32'h4001, 0, 5, 1, 0);
        chk("E R11 stays clear", 32'(overflow), 0);
        chk("E R7 produce", 32'(produce_idx), 1);

        // Frame F: address completes in second fragment
        build(8'hE0, 14);
        send_frame();
        check_frag("F R5 first", 1, 32'h4101, 0, 8, 0, 0);
        check_frag("F R6 second", 2, 32'h4201, 8, 6, 1, 0);
        chk("F R7 produce", 32'(produce_idx), 3);
        chk("F R8 irq", 32'(irq_cnt), 5);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule